// File: doc/BRIEF.md
# Factorized Baud Tick Divider

This block turns a system clock into a strobe that is high for one clock out of every N. It is meant to drive the 16x oversampling of a serial receiver or transmitter. For example, a 51.2 MHz clock divided down to a 921.6 kHz sampling rate needs a ratio of about 55.6. The ratio is fixed when the block is elaborated. No register exists to change it at run time.

At elaboration the block splits the effective ratio into a product of factors, each between 2 and 16. Each factor becomes a short ring of flip-flops in which a single token circulates. A stage moves its token only on a cycle in which the previous stage has produced a cleaned one-cycle pulse. Each pulse is cleaned by a two-register rising-edge detector, so the slow ring outputs never reach the next stage as long high levels.

An exact ratio can be unusable because it has a prime factor above 16. In that case a tolerance, given in parts per thousand of the ratio, lets the block search nearby ratios and take the first one that factors. If no ratio inside the tolerance factors, the block uses a plain modulo counter. A requested ratio below 2 is rejected at elaboration.

Top module: `baud_tick_div`

## Requirements
- R1: `tick_o` is never high on two consecutive cycles. Every tick lasts exactly one clock.
- R2: When the requested ratio factors into values from 2 to 16 (for example 56 = 14 x 4), ticks repeat exactly every RATIO clocks.
- R3: A ratio that needs three or more ring stages (512 = 16 x 16 x 2) keeps an exact period. A ring holds its token still on cycles in which it is not enabled.
- R4: The smallest ratio, 2, produces a tick on every second cycle.
- R5: A ratio with a prime factor above 16 and no tolerance (53 and 221) is built as a modulo counter. Its period is exactly the requested ratio.
- R6: With a tolerance T, the allowed deviation is floor(RATIO*T/1000). Candidates are tried in order of increasing distance, the lower candidate before the upper one at each distance. Candidates below 2 are skipped. Ratio 71 with T=15 gives 70, not 72.
- R7: The search goes past distance 1 when needed. Ratio 93 with T=25 skips 92 and 94 and settles on 91.
- R8: Cycle 1 is the first rising edge at which reset is sampled low. The first tick is high in the cycle after edge P, where P is the effective ratio. Further ticks follow after edges 2P, 3P, and so on.
- R9: While `rst_i` is sampled high, `tick_o` is low in the following cycle. Asserting reset in the middle of a period restarts the phase, so the next tick again comes P cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_o | output | 1 | Registered one-clock strobe, once every effective-ratio clocks |

## Verification
The assertions take two things for granted: reset is sampled high at the very first clock edge, and reset is only ever changed between edges. Reset is the block's only input, so these two points are all they assume about the environment. The stimulus raises reset from time zero and releases it away from the clock edge. Later it asserts reset once more in the middle of a period, so the restart of the token rings and of the counter is seen from a state that is not the reset state. A behavioural cycle count in the bench predicts the tick for seven parameter sets, one after each edge. The sets cover factored, multi-stage, minimal, counter-fallback and tolerance-searched ratios.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  localparam int unsigned FACTOR_MAX  = 16;
  localparam int unsigned STAGE_LIMIT = 32;

  // Largest divisor of n within 2..FACTOR_MAX, or 1 when there is none.
  function automatic int unsigned largest_div(input int unsigned n);
    int unsigned best;
    best = 1;
    for (int unsigned f = 2; f <= FACTOR_MAX; f++) begin
      if ((n % f) == 0) best = f;
    end
    return best;
  endfunction

  // True when n >= 2 and every prime factor of n fits in one stage.
  function automatic bit is_smooth(input int unsigned n);
    int unsigned rem;
    rem = n;
    for (int unsigned p = 2; p <= 13; p++) begin
      for (int unsigned i = 0; i < STAGE_LIMIT; i++) begin
        if (rem != 0 && (rem % p) == 0) rem = rem / p;
      end
    end
    return (n >= 2) && (rem == 1);
  endfunction

  // Nearest ratio inside the tolerance that factors; the lower candidate
  // wins at equal distance. Returns nom when nothing qualifies.
  function automatic int unsigned pick_ratio(input int unsigned nom,
                                             input int unsigned tol_ppt);
    int unsigned span;
    int unsigned result;
    bit          found;
    span   = int'((longint'(nom) * longint'(tol_ppt)) / 1000);
    result = nom;
    found  = is_smooth(nom);
    for (int unsigned d = 1; d <= span; d++) begin
      if (!found) begin
        if (nom >= d + 2 && is_smooth(nom - d)) begin
          result = nom - d;
          found  = 1'b1;
        end else if (is_smooth(nom + d)) begin
          result = nom + d;
          found  = 1'b1;
        end
      end
    end
    return result;
  endfunction

  // Number of stages the greedy split of n produces.
  function automatic int unsigned num_factors(input int unsigned n);
    int unsigned rem;
    int unsigned cnt;
    rem = n;
    cnt = 0;
    for (int unsigned i = 0; i < STAGE_LIMIT; i++) begin
      if (rem > 1) begin
        rem = rem / largest_div(rem);
        cnt++;
      end
    end
    return cnt;
  endfunction

  // Length of stage idx in the greedy split of n.
  function automatic int unsigned factor_at(input int unsigned n,
                                            input int unsigned idx);
    int unsigned rem;
    int unsigned f;
    rem = n;
    f   = 1;
    for (int unsigned i = 0; i < STAGE_LIMIT; i++) begin
      if (i <= idx) begin
        f   = largest_div(rem);
        rem = rem / f;
      end
    end
    return f;
  endfunction

  // Reset position of the token in stage idx. Every stage adds two register
  // delays, so the chain is pre-advanced by 2*stages-1 cycles, spread as
  // mixed-radix digits over the stages; the first tick then lands on P.
  function automatic int unsigned start_pos(input int unsigned n,
                                            input int unsigned idx);
    int unsigned lead;
    int unsigned weight;
    lead   = 2 * num_factors(n) - 1;
    weight = 1;
    for (int unsigned i = 0; i < STAGE_LIMIT; i++) begin
      if (i < idx) weight = weight * factor_at(n, i);
    end
    return (lead / weight) % factor_at(n, idx);
  endfunction

endpackage

// File: rtl/baud_token_ring.sv
module baud_token_ring #(
  parameter int unsigned LEN   = 4,
  parameter int unsigned START = 0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  output logic home_o
);

  logic [LEN-1:0] ring;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int j = 0; j < int'(LEN); j++) ring[j] <= (j == int'(START));
    end else if (adv_i) begin
      ring <= {ring[LEN-2:0], ring[LEN-1]};
    end
  end

  assign home_o = ring[0];

  p_single_token_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(ring) == 1);

  p_frozen_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(ring));

endmodule

// File: rtl/baud_edge_pulse.sv
module baud_edge_pulse (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic pulse_o
);

  logic hist_q;
  logic pulse_q;

  // History presets high so a token already at its tap is not an arrival.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      hist_q  <= lvl_i;
      pulse_q <= lvl_i & ~hist_q;
    end
  end

  assign pulse_o = pulse_q;

  p_one_shot_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/baud_mod_count.sv
module baud_mod_count #(
  parameter int unsigned PERIOD = 53
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick_q <= (cnt_q == LAST);
    end
  end

  assign tick_o = tick_q;

  p_count_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LAST);

  p_wrap_fires_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q == LAST) |=> tick_o);

endmodule

// File: rtl/baud_tick_div.sv
module baud_tick_div #(
  parameter int unsigned RATIO   = 56,
  parameter int unsigned TOL_PPT = 0
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic tick_o
);

  localparam int unsigned EFF    = baud_div_pkg::pick_ratio(RATIO, TOL_PPT);
  localparam bit          SMOOTH = baud_div_pkg::is_smooth(EFF);
  localparam int unsigned NST    = SMOOTH ? baud_div_pkg::num_factors(EFF) : 0;

  generate
    if (RATIO < 2) begin : g_reject
      $error("baud_tick_div: RATIO must be at least 2");
      assign tick_o = 1'b0;
    end else if (SMOOTH) begin : g_rings
      logic [NST:0] chain;
      assign chain[0] = 1'b1;
      for (genvar s = 0; s < NST; s++) begin : g_stage
        localparam int unsigned LEN   = baud_div_pkg::factor_at(EFF, s);
        localparam int unsigned START = baud_div_pkg::start_pos(EFF, s);
        logic home;
        baud_token_ring #(.LEN(LEN), .START(START)) ring_i (
          .clk_i  (clk_i),
          .rst_i  (rst_i),
          .adv_i  (chain[s]),
          .home_o (home)
        );
        baud_edge_pulse clean_i (
          .clk_i   (clk_i),
          .rst_i   (rst_i),
          .lvl_i   (home),
          .pulse_o (chain[s+1])
        );
      end
      assign tick_o = chain[NST];
    end else begin : g_counter
      baud_mod_count #(.PERIOD(EFF)) cnt_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick_o)
      );
    end
  endgenerate

  p_tick_narrow_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o);

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    rst_i |=> !tick_o);

endmodule

// File: tb/baud_tick_div_tb_top.sv
`timescale 1ns/1ps
module baud_tick_div_tb_top;

  localparam int NI = 7;
  // Expected effective periods, worked out from the requirements.
  int    per [NI] = '{56, 53, 70, 512, 91, 221, 2};
  string tag [NI] = '{"R2", "R5", "R6", "R3", "R7", "R5", "R4"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NI-1:0] ticks;
  int compared   = 0;
  int mismatched = 0;
  bit done       = 1'b0;

  always #4 clk = ~clk;

  baud_tick_div #(.RATIO(56),  .TOL_PPT(0))  dut_i  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[0]));
  baud_tick_div #(.RATIO(53),  .TOL_PPT(0))  dut_b  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[1]));
  baud_tick_div #(.RATIO(71),  .TOL_PPT(15)) dut_c  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[2]));
  baud_tick_div #(.RATIO(512), .TOL_PPT(0))  dut_d  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[3]));
  baud_tick_div #(.RATIO(93),  .TOL_PPT(25)) dut_e  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[4]));
  baud_tick_div #(.RATIO(221), .TOL_PPT(0))  dut_f  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[5]));
  baud_tick_div #(.RATIO(2),   .TOL_PPT(0))  dut_g  (.clk_i(clk), .rst_i(rst), .tick_o(ticks[6]));

  initial begin
    int k;
    k = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(posedge clk);
      if (rst) k = 0; else k++;
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
        bit    exp;
        string req;
        exp = (k != 0) && (k % per[i] == 0);
        if (k == 0)                                  req = "R9";
        else if (k <= per[i])                        req = "R8";
        else if (k % per[i] == 1 && per[i] > 1)      req = "R1";
        else                                         req = tag[i];
        compared++;
        if (ticks[i] !== exp) begin
          mismatched++;
          $display("FAIL %s ratio-set %0d cycle %0d: tick=%b expected %0b",
                   req, i, k, ticks[i], exp);
        end
      end
      rst = (cyc < 2) || (cyc >= 1500 && cyc < 1504);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule